// File: doc/BRIEF.md
# Fine-Grained Multithread Issue Selector

This block is the thread-select stage of a single-issue, in-order core that holds four hardware threads. In every cycle it looks at which threads can issue and hands the issue slot to one of them. The search starts from the thread just after the one that issued last, so the slot rotates among the threads and a thread can issue again only after the others have had their chance. Threads that cannot issue are passed over.

A thread cannot issue when it has no valid instruction, when it is inside the three-cycle shadow that follows one of its own loads or branches, or when it has a cache miss outstanding. The shadow is covered only by issuing other threads; the block never inserts a bubble while some thread is ready. A miss blocks its thread until the cache returns the data, with no timeout. When no thread can issue, the block reports the core as idle.

Fetch, caches and the execution pipeline lie outside the block. Decode marks whether a thread's next instruction is a load or branch, and the memory side pulses miss-start and miss-return per thread.

Top module: `fg_thread_sel`

## Requirements
- R1: Four threads are supported; `issue_tid_o` is the binary thread index 0..3, and bit t of each per-thread input bus belongs to thread t.
- R2: The selection is combinational in the same cycle as the inputs. The search starts at the thread after the last one that issued, goes upward and wraps from 3 to 0, and picks the first ready thread.
- R3: During and after reset, nothing is stalled and the search starts at thread 0. The outputs show `issue_vld_o`=0 and `core_idle_o`=1 until some thread has a valid instruction.
- R4: A thread is ready only if its `insn_vld_i` bit is 1, it is outside a shadow, and it has no miss pending. A thread without a valid instruction is skipped.
- R5: If a thread issues in cycle k while its `ldbr_i` bit is 1, it cannot be selected in cycles k+1, k+2 and k+3, and it can be selected again in cycle k+4.
- R6: A `miss_set_i` pulse in cycle k blocks the thread from cycle k+1 onward, with no timeout. The thread can be selected again in the cycle where its `miss_ret_i` bit is 1, and in every cycle after that.
- R7: If `miss_set_i` and `miss_ret_i` are both 1 for a thread in the same cycle, the thread may issue in that cycle, and the new miss is pending from the next cycle.
- R8: If a thread issues a load or branch in the same cycle as its miss return, the miss clears and the thread serves the full shadow, so it can next be selected in cycle k+4.
- R9: `core_idle_o`=1 and `issue_vld_o`=0 exactly when no thread is ready. The rotation position does not move during idle cycles.
- R10: An `ldbr_i` bit has no effect on a thread that is not selected in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_vld_i | input | 4 | Thread has a valid instruction to issue |
| ldbr_i | input | 4 | Thread's next instruction is a load or branch |
| miss_set_i | input | 4 | Cache miss started for the thread |
| miss_ret_i | input | 4 | Miss data returned for the thread |
| issue_vld_o | output | 1 | A thread is issuing this cycle |
| issue_tid_o | output | 2 | Index of the issuing thread |
| core_idle_o | output | 1 | No thread can issue |

## Verification
The assertions check four rules on every cycle: a selected thread always has a valid instruction, no thread issues inside its own shadow, a newly started miss blocks its thread in the next cycle unless the data returns in that cycle, and the core reports idle when no instruction is valid. The fairness of the rotation cannot be seen from one or two cycles of history. The same holds for the exact cycle in which a thread comes back after a shadow or a miss, for the priority between miss start and miss return, and for a pointer that holds still through idle cycles. The bench's scenarios show these by comparing every cycle against its reference model.

// File: rtl/mtsel_pkg.sv
package mtsel_pkg;
  localparam int unsigned DEF_THREADS = 4;
  localparam int unsigned DEF_SHADOW  = 3;

  // next search start after thread cur in a ring of n threads
  function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/mtsel_thread_slot.sv
module mtsel_thread_slot #(
  parameter int unsigned SHADOW_CYC = 3,
  localparam int unsigned CW = $clog2(SHADOW_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic insn_vld,
  input  logic grant,
  input  logic ldbr,
  input  logic miss_set,
  input  logic miss_ret,
  output logic ready
);
  logic [CW-1:0] shadow_q, shadow_d;
  logic          shadow_en;
  logic          miss_q, miss_d, miss_en;
  logic          long_issue;

  assign long_issue = grant && ldbr;
  assign ready      = insn_vld && (shadow_q == '0) && (!miss_q || miss_ret);

  always_comb begin
    shadow_en = long_issue || (shadow_q != '0);
    shadow_d  = shadow_q;
    if (long_issue)              shadow_d = CW'(SHADOW_CYC);
    else if (shadow_q != '0)     shadow_d = shadow_q - 1'b1;
  end

  always_comb begin
    miss_en = miss_set || miss_ret;
    miss_d  = miss_set;     // a new miss outranks a return
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      miss_q   <= 1'b0;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (miss_en)   miss_q   <= miss_d;
    end
  end
endmodule

// File: rtl/mtsel_rr_pick.sv
module mtsel_rr_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned TW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [TW-1:0] start,
  output logic          gnt_vld,
  output logic [TW-1:0] gnt_idx,
  output logic [N-1:0]  gnt_oh
);
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int unsigned i = 0; i < N; i++) begin
      int unsigned idx;
      idx = (int'(start) + i) % N;
      if (!gnt_vld && req[idx]) begin
        gnt_vld = 1'b1;
        gnt_idx = TW'(idx);
      end
    end
  end

  for (genvar t = 0; t < N; t++) begin : g_oh
    assign gnt_oh[t] = gnt_vld && (gnt_idx == TW'(t));
  end
endmodule

// File: rtl/fg_thread_sel.sv
module fg_thread_sel #(
  parameter int unsigned N_THREADS  = mtsel_pkg::DEF_THREADS,
  parameter int unsigned SHADOW_CYC = mtsel_pkg::DEF_SHADOW,
  localparam int unsigned TID_W = $clog2(N_THREADS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_THREADS-1:0] insn_vld_i,
  input  logic [N_THREADS-1:0] ldbr_i,
  input  logic [N_THREADS-1:0] miss_set_i,
  input  logic [N_THREADS-1:0] miss_ret_i,
  output logic                 issue_vld_o,
  output logic [TID_W-1:0]     issue_tid_o,
  output logic                 core_idle_o
);
  logic [N_THREADS-1:0] ready;
  logic [N_THREADS-1:0] grant_oh;
  logic                 gnt_vld;
  logic [TID_W-1:0]     gnt_idx;
  logic [TID_W-1:0]     ptr_q, ptr_d;
  logic                 ptr_en;

  for (genvar t = 0; t < N_THREADS; t++) begin : g_slot
    mtsel_thread_slot #(.SHADOW_CYC(SHADOW_CYC)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .insn_vld (insn_vld_i[t]),
      .grant    (grant_oh[t]),
      .ldbr     (ldbr_i[t]),
      .miss_set (miss_set_i[t]),
      .miss_ret (miss_ret_i[t]),
      .ready    (ready[t])
    );
  end

  mtsel_rr_pick #(.N(N_THREADS)) u_pick (
    .req     (ready),
    .start   (ptr_q),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx),
    .gnt_oh  (grant_oh)
  );

  always_comb begin
    ptr_en = gnt_vld;
    ptr_d  = TID_W'(mtsel_pkg::ring_next(int'(gnt_idx), N_THREADS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign issue_vld_o = gnt_vld;
  assign issue_tid_o = gnt_idx;
  assign core_idle_o = !gnt_vld;
endmodule

// File: rtl/mtsel_chk.sv
module mtsel_chk #(
  parameter int unsigned N_THREADS  = 4,
  parameter int unsigned SHADOW_CYC = 3,
  localparam int unsigned TID_W = $clog2(N_THREADS),
  localparam int unsigned CW    = $clog2(SHADOW_CYC + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_THREADS-1:0] insn_vld_i,
  input logic [N_THREADS-1:0] ldbr_i,
  input logic [N_THREADS-1:0] miss_set_i,
  input logic [N_THREADS-1:0] miss_ret_i,
  input logic                 issue_vld_o,
  input logic [TID_W-1:0]     issue_tid_o,
  input logic                 core_idle_o
);
  AST_ISSUE_HAS_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld_o |-> insn_vld_i[issue_tid_o]); // R4

  AST_NONE_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld_i == '0) |-> (core_idle_o && !issue_vld_o)); // R9

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    logic [CW-1:0] win_q;
    logic          sel_t;
    assign sel_t = issue_vld_o && (issue_tid_o == TID_W'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     win_q <= '0;
      else if (sel_t && ldbr_i[t])    win_q <= CW'(SHADOW_CYC);
      else if (win_q != '0)           win_q <= win_q - 1'b1;
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sel_t |-> (win_q == '0)); // R5

    AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      miss_set_i[t] |=> (!sel_t || miss_ret_i[t])); // R6
  end
endmodule

bind fg_thread_sel mtsel_chk #(.N_THREADS(N_THREADS), .SHADOW_CYC(SHADOW_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_vld_i(insn_vld_i), .ldbr_i(ldbr_i),
  .miss_set_i(miss_set_i), .miss_ret_i(miss_ret_i), .issue_vld_o(issue_vld_o),
  .issue_tid_o(issue_tid_o), .core_idle_o(core_idle_o)
);

// File: tb/tb_fg_thread_sel.sv
module tb_fg_thread_sel;
  logic       clk;
  logic       rst_n;
  logic [3:0] insn_vld_i, ldbr_i, miss_set_i, miss_ret_i;
  logic       issue_vld_o, core_idle_o;
  logic [1:0] issue_tid_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  int m_cnt[4];
  bit m_miss[4];
  int m_ptr;

  fg_thread_sel dut (
    .clk(clk), .rst_n(rst_n), .insn_vld_i(insn_vld_i), .ldbr_i(ldbr_i),
    .miss_set_i(miss_set_i), .miss_ret_i(miss_ret_i), .issue_vld_o(issue_vld_o),
    .issue_tid_o(issue_tid_o), .core_idle_o(core_idle_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one cycle: compare outputs mid-cycle, then advance the model at the edge
  task automatic cyc(input string req);
    bit ev;
    int es;
    @(negedge clk);
    ev = 0; es = 0;
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        int t;
        t = (m_ptr + i) % 4;
        if (!ev && insn_vld_i[t] && m_cnt[t] == 0 && (!m_miss[t] || miss_ret_i[t])) begin
          ev = 1; es = t;
        end
      end
    end
    chk(req, "issue_vld", int'(issue_vld_o), int'(ev));
    chk(req, "core_idle", int'(core_idle_o), int'(!ev));
    if (ev) chk(req, "issue_tid", int'(issue_tid_o), es);
    @(posedge clk);
    if (rst_n) begin
      for (int t = 0; t < 4; t++) begin
        if (ev && es == t && ldbr_i[t]) m_cnt[t] = 3;
        else if (m_cnt[t] > 0) m_cnt[t] = m_cnt[t] - 1;
        if (miss_set_i[t]) m_miss[t] = 1;
        else if (miss_ret_i[t]) m_miss[t] = 0;
      end
      if (ev) m_ptr = (es + 1) % 4;
    end
    #1;
  endtask

  task automatic drive(input logic [3:0] v, input logic [3:0] lb,
                       input logic [3:0] ms, input logic [3:0] mr);
    insn_vld_i = v; ldbr_i = lb; miss_set_i = ms; miss_ret_i = mr;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < 4; t++) begin m_cnt[t] = 0; m_miss[t] = 0; end
    m_ptr = 0;
    rst_n = 1'b0;
    drive(4'h0, 4'h0, 4'h0, 4'h0);
    // R3: reset state is idle
    repeat (3) cyc("R3");
    rst_n = 1'b1;
    cyc("R3");
    // R3: first issue after reset is thread 0
    drive(4'hF, 4'h0, 4'h0, 4'h0);
    cyc("R3");
    // R1 R2: full rotation with all threads ready
    repeat (8) cyc("R2");
    // R4: only threads 0 and 2 valid
    drive(4'b0101, 4'h0, 4'h0, 4'h0);
    repeat (4) cyc("R4");
    drive(4'b1000, 4'h0, 4'h0, 4'h0);
    repeat (2) cyc("R1");
    // R5: thread 0 alone with back-to-back loads: issue, 3 idle, issue
    drive(4'b0001, 4'b0001, 4'h0, 4'h0);
    repeat (9) cyc("R5");
    // R5: shadow hidden by other threads
    drive(4'hF, 4'b0010, 4'h0, 4'h0);
    repeat (8) cyc("R5");
    // R6: miss on thread 1 held for many cycles, then returned
    drive(4'hF, 4'h0, 4'b0010, 4'h0);
    cyc("R6");
    drive(4'hF, 4'h0, 4'h0, 4'h0);
    repeat (20) cyc("R6");
    drive(4'b0010, 4'h0, 4'h0, 4'h0);
    repeat (3) cyc("R6");
    drive(4'b0010, 4'h0, 4'h0, 4'b0010);
    cyc("R6");
    drive(4'b0010, 4'h0, 4'h0, 4'h0);
    repeat (2) cyc("R6");
    // R7: simultaneous start and return on thread 3
    drive(4'b1000, 4'h0, 4'b1000, 4'h0);
    cyc("R7");
    drive(4'b1000, 4'h0, 4'b1000, 4'b1000);
    cyc("R7");
    drive(4'b1000, 4'h0, 4'h0, 4'h0);
    repeat (3) cyc("R7");
    drive(4'b1000, 4'h0, 4'h0, 4'b1000);
    cyc("R7");
    // R8: load issued in the cycle of its miss return on thread 2
    drive(4'b0100, 4'h0, 4'b0100, 4'h0);
    cyc("R8");
    drive(4'b0100, 4'h0, 4'h0, 4'h0);
    repeat (2) cyc("R8");
    drive(4'b0100, 4'b0100, 4'h0, 4'b0100);
    cyc("R8");
    drive(4'b0100, 4'h0, 4'h0, 4'h0);
    repeat (5) cyc("R8");
    // R10: load flag on a thread that is not selected has no effect
    drive(4'b0001, 4'b0010, 4'h0, 4'h0);
    repeat (2) cyc("R10");
    drive(4'b0010, 4'h0, 4'h0, 4'h0);
    repeat (2) cyc("R10");
    // R9: pointer holds through idle cycles
    drive(4'b0010, 4'h0, 4'h0, 4'h0);
    cyc("R9");
    drive(4'h0, 4'h0, 4'h0, 4'h0);
    repeat (4) cyc("R9");
    drive(4'hF, 4'h0, 4'h0, 4'h0);
    repeat (2) cyc("R9");
    // R2: mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [3:0] v, lb, ms, mr;
      v  = 4'($urandom) | 4'($urandom);
      lb = 4'($urandom) & 4'($urandom);
      ms = 4'($urandom) & 4'($urandom) & 4'($urandom);
      mr = 4'($urandom) & 4'($urandom);
      drive(v, lb, ms, mr);
      cyc("R2");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end
endmodule